// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several requesters, called localities, owns a shared command interface. Each locality has its own register page. The locality number is taken from the address bits directly above the page offset. A single byte-wide ownership register sits at offset zero of every page. Software writes it to ask for the interface, to give it up, to take it over from a lower-numbered owner, or to acknowledge that it lost the interface. The arbiter drives the current owner on its outputs, or shows that nobody owns the interface.

When ownership has to move while the command engine reports a command in progress, the arbiter does not move it at once. It raises an abort request and keeps the current owner until the engine acknowledges the abort. Whenever a locality becomes the owner, the arbiter emits a one-cycle locality-changed event. The top locality is reserved for hardware, so bus writes to its page are dropped.

Top module: `locarb_top`

## Requirements
- R1: After reset no locality owns the interface, all request, takeover and lost-ownership flags are clear, abort_req and loc_changed are low, and a read of any ownership register returns 0x80 plus the establishment input in bit 0.
- R2: A write with bit 1 (request) set grants ownership to the writer in that cycle when no locality owns the interface. Otherwise it sets the writer's request flag, which reads back in bit 1.
- R3: The owner writing bit 5 (active) gives up ownership. The highest-numbered locality with its request flag set becomes the owner. If no flag is set, no locality owns the interface.
- R4: A non-owner writing bit 5 clears its own request flag.
- R5: A takeover write (bit 3) is accepted only when no locality owns the interface or the writer's number is above the owner's. It is refused while a higher locality's takeover is waiting. Accepting it clears the takeover flags of lower localities. Bit 3 always reads as 0, and a takeover write also discards bits 1 and 5 of the same write.
- R6: On a takeover handoff the old owner loses the active bit and gains the lost-ownership flag (bit 4). On a normal handoff the old owner loses the active bit and its request flag, and its bit 4 is not set.
- R7: The new owner reads bit 5 set, with its request and takeover flags cleared. loc_changed pulses for exactly one cycle whenever a locality becomes the owner.
- R8: Bit 2 of a locality's read value is 1 exactly when some other locality has its request flag set.
- R9: Writing 1 to bit 4 clears the writer's lost-ownership flag.
- R10: Writes to the hardware locality (4) and to locality numbers 5 to 7 have no effect. Reads of locality numbers 5 to 7, or of any offset other than zero, return 0xFF.
- R11: If cmd_busy is high when a handoff is due, abort_req rises at that edge and the owner is held. The handoff takes place at the edge where abort_ack is sampled high, and abort_req falls at the same edge. A later handoff that comes due while one is waiting replaces its target.
- R12: Read data appears on rdata at the clock edge that samples rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 15 | Byte address: locality in bits 14:12, page offset below |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| estab_in | input | 1 | Establishment flag reflected in read bit 0 |
| cmd_busy | input | 1 | Command engine is executing a command |
| abort_ack | input | 1 | Command engine has finished the abort |
| abort_req | output | 1 | Abort requested; handoff waiting |
| active_vld | output | 1 | Some locality owns the interface |
| active_loc | output | 3 | Owning locality number |
| loc_changed | output | 1 | One-cycle pulse when a locality becomes owner |

## Verification
Every result is registered. Ownership, abort_req and loc_changed take their new values at the edge that samples the write, or at the edge that samples abort_ack for a deferred handoff. rdata changes at the edge that samples rd_en. The bench drives inputs and compares at the falling edge. A behavioural model updates at each rising edge from the inputs it sampled there, so every output is checked half a cycle after the edge that produced it. Directed read-backs check the register bits one edge after each read strobe.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
  localparam int ACC_EST    = 0;
  localparam int ACC_REQ    = 1;
  localparam int ACC_PEND   = 2;
  localparam int ACC_SEIZE  = 3;
  localparam int ACC_SEIZED = 4;
  localparam int ACC_ACTIVE = 5;
  localparam int ACC_VALID  = 7;
  // Writable command bits: request, takeover, lost-ownership ack, active.
  localparam logic [7:0] ACC_WMASK   = 8'h3A;
  localparam logic [7:0] NO_REG_BYTE = 8'hFF;
endpackage

// File: rtl/locarb_decode.sv
module locarb_decode #(
  parameter int NUM_LOC   = 5,
  parameter int LOC_W     = 3,
  parameter int PAGE_BITS = 12,
  parameter int HW_LOC    = 4,
  parameter int ADDR_W    = PAGE_BITS + LOC_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [LOC_W-1:0]  loc,
  output logic              rd_hit,
  output logic              wr_hit
);
  logic at_reg;
  logic loc_ok;

  assign loc    = addr[PAGE_BITS +: LOC_W];
  assign at_reg = (addr[PAGE_BITS-1:0] == '0);
  assign loc_ok = (int'(loc) < NUM_LOC);
  assign rd_hit = rd_en && at_reg && loc_ok;
  assign wr_hit = wr_en && at_reg && loc_ok && (int'(loc) != HW_LOC);
endmodule

// File: rtl/locarb_prio.sv
module locarb_prio #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seize,
  output logic               hi_vld,
  output logic [LOC_W-1:0]   hi_idx,
  output logic [NUM_LOC-1:0] others_req,
  output logic [NUM_LOC-1:0] seize_above
);
  always_comb begin
    hi_vld = 1'b0;
    hi_idx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req[i]) begin
        hi_vld = 1'b1;
        hi_idx = LOC_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_per_loc
    localparam logic [NUM_LOC-1:0] SELF  = NUM_LOC'(1) << g;
    localparam logic [NUM_LOC-1:0] UPPER = ~((SELF << 1) - NUM_LOC'(1));
    assign others_req[g]  = |(req & ~SELF);
    assign seize_above[g] = |(seize & UPPER);
  end
endmodule

// File: rtl/locarb_readback.sv
module locarb_readback #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               rd_hit,
  input  logic [LOC_W-1:0]   loc,
  input  logic               own_vld,
  input  logic [LOC_W-1:0]   own,
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seized,
  input  logic [NUM_LOC-1:0] others_req,
  input  logic               est,
  output logic [7:0]         rdata
);
  import locarb_pkg::*;
  logic [7:0] rbyte;

  always_comb begin
    rbyte = NO_REG_BYTE;
    if (rd_hit) begin
      rbyte             = '0;
      rbyte[ACC_VALID]  = 1'b1;
      rbyte[ACC_ACTIVE] = own_vld && (own == loc);
      rbyte[ACC_SEIZED] = seized[loc];
      rbyte[ACC_PEND]   = others_req[loc];
      rbyte[ACC_REQ]    = req[loc];
      rbyte[ACC_EST]    = est;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rbyte;
  end
endmodule

// File: rtl/locarb_top.sv
module locarb_top #(
  parameter int NUM_LOC   = 5,
  parameter int PAGE_BITS = 12,
  parameter int HW_LOC    = 4,
  parameter int LOC_W     = $clog2(NUM_LOC),
  parameter int ADDR_W    = PAGE_BITS + LOC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              estab_in,
  input  logic              cmd_busy,
  input  logic              abort_ack,
  output logic              abort_req,
  output logic              active_vld,
  output logic [LOC_W-1:0]  active_loc,
  output logic              loc_changed
);
  import locarb_pkg::*;

  typedef struct packed {
    logic [NUM_LOC-1:0] req;
    logic [NUM_LOC-1:0] seize;
    logic [NUM_LOC-1:0] seized;
    logic               own_v;
    logic [LOC_W-1:0]   own;
  } arb_st_t;

  arb_st_t            cur, nxt;
  logic               pend_v_q, pend_v_d;
  logic [LOC_W-1:0]   pend_q, pend_d;
  logic               chg_d, chg_q;

  logic [LOC_W-1:0]   loc;
  logic               rd_hit, wr_hit;
  logic               hi_vld;
  logic [LOC_W-1:0]   hi_idx;
  logic [NUM_LOC-1:0] others_req, seize_above;

  locarb_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .PAGE_BITS(PAGE_BITS),
                  .HW_LOC(HW_LOC), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .loc(loc), .rd_hit(rd_hit), .wr_hit(wr_hit));

  locarb_prio #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_prio (
    .req(cur.req), .seize(cur.seize), .hi_vld(hi_vld), .hi_idx(hi_idx),
    .others_req(others_req), .seize_above(seize_above));

  locarb_readback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_hit(rd_hit), .loc(loc),
    .own_vld(cur.own_v), .own(cur.own), .req(cur.req), .seized(cur.seized),
    .others_req(others_req), .est(estab_in), .rdata(rdata));

  // Move ownership to (tv, t), updating the flags of old and new owner.
  function automatic arb_st_t handoff(arb_st_t s, logic tv, logic [LOC_W-1:0] t);
    arb_st_t r;
    logic    moving;
    logic    by_seize;
    r        = s;
    moving   = (s.own_v != tv) || (tv && (s.own != t));
    by_seize = tv && s.seize[t];
    if (moving && s.own_v) begin
      if (by_seize) r.seized[s.own] = 1'b1;
      else          r.req[s.own]    = 1'b0;
    end
    r.own_v = tv;
    r.own   = tv ? t : s.own;
    if (tv) begin
      r.req[t]   = 1'b0;
      r.seize[t] = 1'b0;
    end
    return r;
  endfunction

  logic [7:0]       wv;
  logic             keep_v;
  logic [LOC_W-1:0] keep_l;
  logic             set_new;
  logic             do_prep;
  logic [LOC_W-1:0] prep_t;
  logic             seize_ok;

  always_comb begin
    nxt      = cur;
    pend_v_d = pend_v_q;
    pend_d   = pend_q;
    wv       = wdata & ACC_WMASK;
    keep_v   = cur.own_v;
    keep_l   = cur.own;
    set_new  = 1'b1;
    do_prep  = 1'b0;
    prep_t   = '0;
    seize_ok = 1'b0;
    if (pend_v_q && abort_ack) begin
      nxt      = handoff(cur, 1'b1, pend_q);
      pend_v_d = 1'b0;
    end else if (wr_hit) begin
      if (wv[ACC_SEIZE]) begin
        wv[ACC_REQ]    = 1'b0;
        wv[ACC_ACTIVE] = 1'b0;
      end
      if (wv[ACC_ACTIVE]) begin
        if (cur.own_v && (cur.own == loc)) begin
          if (hi_vld) begin
            set_new = 1'b0;
            do_prep = 1'b1;
            prep_t  = hi_idx;
          end else begin
            keep_v = 1'b0;
          end
        end else begin
          nxt.req[loc] = 1'b0;
        end
      end
      if (wv[ACC_SEIZED]) nxt.seized[loc] = 1'b0;
      if (wv[ACC_SEIZE]) begin
        seize_ok = (!cur.own_v || (loc > cur.own)) && !cur.seize[loc] && !seize_above[loc];
        if (seize_ok) begin
          for (int j = 0; j < NUM_LOC; j++) begin
            if (LOC_W'(j) < loc) nxt.seize[j] = 1'b0;
          end
          nxt.seize[loc] = 1'b1;
          set_new = 1'b0;
          do_prep = 1'b1;
          prep_t  = loc;
        end
      end
      if (wv[ACC_REQ] && !(cur.own_v && (cur.own == loc))) begin
        if (cur.own_v) nxt.req[loc] = 1'b1;
        else begin
          keep_v = 1'b1;
          keep_l = loc;
        end
      end
      if (do_prep) begin
        if (cmd_busy) begin
          pend_v_d = 1'b1;
          pend_d   = prep_t;
        end else begin
          nxt = handoff(nxt, 1'b1, prep_t);
        end
      end else if (set_new) begin
        nxt = handoff(nxt, keep_v, keep_l);
      end
    end
    chg_d = nxt.own_v && (!cur.own_v || (nxt.own != cur.own));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      chg_q    <= 1'b0;
    end else begin
      cur      <= nxt;
      pend_v_q <= pend_v_d;
      pend_q   <= pend_d;
      chg_q    <= chg_d;
    end
  end

  assign abort_req   = pend_v_q;
  assign active_vld  = cur.own_v;
  assign active_loc  = cur.own;
  assign loc_changed = chg_q;

  // R11
  abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
    abort_req && !abort_ack |=> abort_req);

  // R11
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    abort_req && !abort_ack && !wr_en |=> $stable(active_loc) && $stable(active_vld));

  // R7
  change_owner_chk: assert property (@(posedge clk) disable iff (rst)
    loc_changed |-> active_vld);

  // R7
  owner_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    active_vld |-> !cur.req[active_loc] && !cur.seize[active_loc]);

  // R5
  seize_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cur.seize));

  // R10
  hw_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && (int'(addr[PAGE_BITS +: LOC_W]) == HW_LOC) && !abort_req
    |=> $stable(cur.req) && $stable(cur.seize) && $stable(cur.seized) && $stable(active_vld));
endmodule

// File: tb/tb_locarb_top.sv
`timescale 1ns/1ps
module tb_locarb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        estab_in = 1'b0, cmd_busy = 1'b0, abort_ack = 1'b0;
  logic        abort_req, active_vld, loc_changed;
  logic [2:0]  active_loc;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  locarb_top dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .estab_in(estab_in), .cmd_busy(cmd_busy),
    .abort_ack(abort_ack), .abort_req(abort_req), .active_vld(active_vld),
    .active_loc(active_loc), .loc_changed(loc_changed));

  // Behavioural reference model
  int  m_own = -1, m_pend = -1;
  bit  m_req[5], m_seize[5], m_seized[5];
  bit  m_chg = 0, m_rdv = 0;
  int  m_rd = 0;

  task automatic m_hand(input int t);
    bit ch = (t != m_own);
    if (ch && m_own >= 0) begin
      if (t >= 0 && m_seize[t]) m_seized[m_own] = 1;
      else m_req[m_own] = 0;
    end
    m_own = t;
    if (t >= 0) begin m_req[t] = 0; m_seize[t] = 0; end
    if (ch && t >= 0) m_chg = 1;
  endtask

  function automatic int m_read(input int l, input int off);
    int r, p;
    if (off != 0 || l > 4) return 255;
    p = 0;
    for (int c = 0; c < 5; c++) if (c != l && m_req[c]) p = 1;
    r = 128 + ((m_own == l) ? 32 : 0) + (m_seized[l] ? 16 : 0) + p * 4
        + (m_req[l] ? 2 : 0) + (estab_in ? 1 : 0);
    return r;
  endfunction

  task automatic m_write(input int l, input logic [7:0] v);
    int nt = m_own, prep = -1, hi = -1;
    bit setnew = 1, ok;
    if (v[3]) begin v[1] = 0; v[5] = 0; end
    if (v[5]) begin
      if (m_own == l) begin
        for (int c = 0; c < 5; c++) if (m_req[c]) hi = c;
        if (hi >= 0) begin setnew = 0; prep = hi; end else nt = -1;
      end else m_req[l] = 0;
    end
    if (v[4]) m_seized[l] = 0;
    if (v[3]) begin
      ok = (m_own < 0 || l > m_own) && !m_seize[l];
      for (int j = l + 1; j < 5; j++) if (m_seize[j]) ok = 0;
      if (ok) begin
        for (int j = 0; j < l; j++) m_seize[j] = 0;
        m_seize[l] = 1; setnew = 0; prep = l;
      end
    end
    if (v[1] && m_own != l) begin
      if (m_own >= 0) m_req[l] = 1; else nt = l;
    end
    if (prep >= 0) begin
      if (cmd_busy) m_pend = prep; else m_hand(prep);
    end else if (setnew) m_hand(nt);
  endtask

  always @(posedge clk) begin
    int l, off;
    l = addr[14:12]; off = addr[11:0];
    m_chg = 0;
    if (rst) begin
      m_own = -1; m_pend = -1; m_rd = 0; m_rdv = 0;
      for (int c = 0; c < 5; c++) begin m_req[c] = 0; m_seize[c] = 0; m_seized[c] = 0; end
    end else begin
      m_rdv = rd_en;
      if (rd_en) m_rd = m_read(l, off);
      if (m_pend >= 0 && abort_ack) begin m_hand(m_pend); m_pend = -1; end
      else if (wr_en && off == 0 && l < 4) m_write(l, wdata);
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (active_vld !== (m_own >= 0) || (m_own >= 0 && active_loc !== 3'(m_own)) ||
          abort_req !== (m_pend >= 0) || loc_changed !== m_chg || rdata !== 8'(m_rd)) begin
        fails++;
        $display("FAIL %s cycle: act=%0b/%0d abort=%0b chg=%0b rd=%02h exp act=%0d abort=%0b chg=%0b rd=%02h",
          cur_req, active_vld, active_loc, abort_req, loc_changed, rdata,
          m_own, (m_pend >= 0), m_chg, 8'(m_rd));
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int l, input logic [7:0] d);
    @(negedge clk); addr = {3'(l), 12'h000}; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input int l, input int off, input int exp, input string tag);
    @(negedge clk); addr = {3'(l), 12'(off)}; rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(rdata == 8'(exp), tag, rdata, exp);
  endtask

  task automatic own_chk(input int exp, input string tag);
    if (exp < 0) chk(!active_vld, tag, active_vld, 0);
    else chk(active_vld && active_loc == 3'(exp), tag, active_vld ? active_loc : 7, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    own_chk(-1, "R1 no owner");
    chk(!abort_req && !loc_changed, "R1 idle outputs", abort_req, 0);
    rd_chk(0, 0, 8'h80, "R1 reset read");
    estab_in = 1;
    rd_chk(3, 0, 8'h81, "R1 establishment bit");
    estab_in = 0;

    cur_req = "R2";
    wr(1, 8'h02);
    own_chk(1, "R2 immediate grant");
    chk(loc_changed, "R7 pulse on grant", loc_changed, 1);
    rd_chk(1, 0, 8'hA0, "R12 R2 owner read");
    wr(0, 8'h02);
    wr(2, 8'h02);
    own_chk(1, "R2 owner kept");
    cur_req = "R8";
    rd_chk(1, 0, 8'hA4, "R8 owner sees pending");
    rd_chk(0, 0, 8'h86, "R8 R2 requester flags");

    cur_req = "R3";
    wr(1, 8'h20);
    own_chk(2, "R3 highest requester wins");
    chk(loc_changed, "R7 pulse on handoff", loc_changed, 1);
    rd_chk(1, 0, 8'h84, "R6 normal handoff no lost flag");
    rd_chk(2, 0, 8'hA4, "R7 new owner flags");

    cur_req = "R4";
    wr(0, 8'h20);
    rd_chk(0, 0, 8'h80, "R4 request withdrawn");
    own_chk(2, "R4 owner unchanged");

    cur_req = "R5";
    wr(1, 8'h08);
    own_chk(2, "R5 lower takeover refused");
    rd_chk(1, 0, 8'h80, "R5 takeover bit hidden");
    wr(3, 8'h02);
    wr(3, 8'h08);
    own_chk(3, "R5 higher takeover accepted");
    cur_req = "R6";
    rd_chk(2, 0, 8'h90, "R6 old owner lost flag");
    rd_chk(3, 0, 8'hA0, "R7 takeover owner flags");

    cur_req = "R9";
    wr(2, 8'h10);
    rd_chk(2, 0, 8'h80, "R9 lost flag cleared");

    cur_req = "R10";
    wr(4, 8'h02);
    rd_chk(4, 0, 8'h80, "R10 hw locality write dropped");
    wr(5, 8'h02);
    own_chk(3, "R10 invalid locality write dropped");
    rd_chk(5, 0, 8'hFF, "R10 invalid locality read");
    rd_chk(0, 12'h018, 8'hFF, "R10 other offset read");

    cur_req = "R11";
    cmd_busy = 1;
    wr(1, 8'h02);
    wr(3, 8'h20);
    chk(abort_req, "R11 abort raised", abort_req, 1);
    own_chk(3, "R11 owner held");
    repeat (3) @(negedge clk);
    chk(abort_req, "R11 abort still held", abort_req, 1);
    own_chk(3, "R11 owner still held");
    abort_ack = 1; @(negedge clk); abort_ack = 0;
    own_chk(1, "R11 handoff on ack");
    chk(!abort_req && loc_changed, "R11 abort dropped with change", {abort_req, loc_changed}, 1);

    cur_req = "R5";
    wr(3, 8'h08);
    chk(abort_req, "R5 R11 deferred takeover", abort_req, 1);
    wr(2, 8'h08);
    rd_chk(2, 0, 8'h80, "R5 refused under higher takeover");
    abort_ack = 1; @(negedge clk); abort_ack = 0;
    own_chk(3, "R5 takeover completes");
    rd_chk(1, 0, 8'h90, "R6 deferred takeover lost flag");
    cmd_busy = 0;

    cur_req = "R3";
    wr(3, 8'h20);
    own_chk(-1, "R3 release with no requester");
    chk(!loc_changed, "R7 no pulse when none owns", loc_changed, 0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule